// File: doc/BRIEF.md
# Edge-Captured Interrupt Request Latch Bank

This block captures eight active-low interrupt request lines into sticky latches. Each latch is set by a falling edge on its line, and the line has to go high and fall again before the latch can set a second time. Software reaches the block through four consecutive byte-wide I/O addresses. One address reads back the raw latch states and, on a write, sets which channels may raise an interrupt. One address holds chosen latches cleared. One address carries two card-level control bits.

A response unit further down the chip prioritizes the masked latch outputs and builds a vector. When it services a channel, it sends a one-hot auto-clear pulse back to this block. Each set latch also drives an active-low acknowledge indicator. The mask gates only what leaves the block: it never changes the latch itself, and it never changes what a poll read returns.

Top module: `irq_latch_bank`

## Requirements
- R1: A request line sampled high on one rising clock edge and low on the next sets its latch. The set state is visible on `latch_raw` after the second rising edge that follows the edge that first sampled the line low.
- R2: A line that stays low sets its latch only once. If the latch is then cleared, it stays clear until the line has gone high and fallen again.
- R3: A read of offset 0 (address bits [1:0] = 00, within the window) returns the eight latch states, bit n = channel n, 1 = set. The mask and the control bits do not affect this value.
- R4: A write to offset 0 loads the mask. `latch_gated` bit n is 1 only when latch n is set and mask bit n is 1. The mask resets to all zeros.
- R5: Changing the mask never clears a latch, and a masked channel still sets on a falling edge.
- R6: A write to offset 1 loads the hold register. While hold bit n is 0, latch n is cleared and cannot set. The register resets to all zeros.
- R7: A write to offset 2 loads only data bits 0 and 1; bits 2 to 7 are ignored. Bit 0 = 1 forces `latch_gated` to zero and drives `card_off` high. Bit 1 = 1 drives `chain_block` high. Both bits reset to 0.
- R8: An `auto_clr` bit held high for one cycle clears that latch at the next rising edge, even if a falling edge would set it on the same edge.
- R9: `ack_n` bit n is low exactly when latch n is set.
- R10: The window is the four addresses starting at `BASE_ADDR` (a multiple of four, default 0xCC). A read anywhere in the window raises `bus_rd_hit`. Reads of offsets 1, 2 and 3 return 0x00. A read outside the window returns 0x00 with `bus_rd_hit` low. Writes to offset 3, or to any address outside the window, change nothing.
- R11: Synchronous reset clears all latches, the mask, the hold register and both control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_n | input | 8 | Active-low request lines, asynchronous |
| auto_clr | input | 8 | One-hot latch clear from the response unit |
| bus_addr | input | 8 | I/O address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0x00 when not selected |
| bus_rd_hit | output | 1 | High when a read targets the window |
| latch_raw | output | 8 | Raw latch states |
| latch_gated | output | 8 | Latch states after mask and card disable |
| ack_n | output | 8 | Active-low acknowledge indicators |
| card_off | output | 1 | Card disable control bit |
| chain_block | output | 1 | Priority pass-down disable control bit |

## Verification
The assertions check these properties on every cycle:
- a gated output never appears without its raw latch;
- disabling the card silences the gated outputs;
- a held or auto-cleared latch is clear one edge later;
- poll reads and reads of unused window addresses return the right data.

Some behaviour can only be shown by the bench's scenarios, which compare against a behavioural model on every clock:
- the two-edge capture delay;
- that a line held low fires only once;
- that clear wins when it coincides with an edge;
- that a mask change leaves the latches intact;
- that writes to unused or foreign addresses are ignored.

// File: rtl/irq_latch_pkg.sv
// Shared constants for the interrupt request latch bank.
package irq_latch_pkg;
    localparam int NCH  = 8;   // request channels, also the port data width
    localparam int AW   = 8;   // I/O address width
    localparam int NCTL = 2;   // implemented control bits

    // Offsets inside the four-address window
    typedef enum logic [1:0] {
        OFS_POLL_MASK = 2'd0,
        OFS_HOLD      = 2'd1,
        OFS_CTRL      = 2'd2,
        OFS_SPARE     = 2'd3
    } port_ofs_e;

    localparam int CTRL_CARD_OFF  = 0;
    localparam int CTRL_CHAIN_BLK = 1;
endpackage

// File: rtl/irq_req_sync.sv
// Two-flop synchronizer plus falling-edge detector for each request line.
// Assumes asynchronous, active-low inputs that idle high; the flops reset high.
module irq_req_sync #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_n,
    output logic [N-1:0] fall
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_ch
            logic s1, s2, prev;
            // Bring the line into the clock domain and keep one cycle of history
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s1   <= 1'b1;
                    s2   <= 1'b1;
                    prev <= 1'b1;
                end else begin
                    s1   <= req_n[i];
                    s2   <= s1;
                    prev <= s2;
                end
            end
            // A high-to-low transition of the synchronized line
            assign fall[i] = prev & ~s2;
        end
    endgenerate
endmodule

// File: rtl/irq_latch_core.sv
// Sticky request latches. A clear from the hold register or from auto-clear
// takes priority over a set on the same edge.
module irq_latch_core #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] fall,
    input  logic [N-1:0] hold_n,
    input  logic [N-1:0] auto_clr,
    output logic [N-1:0] latch_q
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_lat
            // Update one latch: reset, then clear, then set
            always_ff @(posedge clk) begin
                if (!rst_n)
                    latch_q[i] <= 1'b0;
                else if (!hold_n[i] || auto_clr[i])
                    latch_q[i] <= 1'b0;
                else if (fall[i])
                    latch_q[i] <= 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/irq_port_regs.sv
// Address decode, software registers and read mux for the four-address window.
// Assumes BASE is a multiple of four. Reads are combinational.
module irq_port_regs
    import irq_latch_pkg::*;
#(
    parameter logic [AW-1:0] BASE = 8'hCC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_rd,
    input  logic            bus_wr,
    input  logic [NCH-1:0]  bus_wdata,
    input  logic [NCH-1:0]  latch_q,
    output logic [NCH-1:0]  bus_rdata,
    output logic            bus_rd_hit,
    output logic [NCH-1:0]  mask_q,
    output logic [NCH-1:0]  hold_q,
    output logic [NCTL-1:0] ctrl_q
);
    logic      in_win;
    port_ofs_e ofs;

    assign in_win = (bus_addr[AW-1:2] == BASE[AW-1:2]);
    assign ofs    = port_ofs_e'(bus_addr[1:0]);

    // Load the writable registers from the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            hold_q <= '0;
            ctrl_q <= '0;
        end else if (bus_wr && in_win) begin
            case (ofs)
                OFS_POLL_MASK: mask_q <= bus_wdata;
                OFS_HOLD:      hold_q <= bus_wdata;
                OFS_CTRL:      ctrl_q <= bus_wdata[NCTL-1:0];
                default:       ;
            endcase
        end
    end

    // Drive read data; only the poll offset returns anything but zero
    always_comb begin
        bus_rd_hit = bus_rd && in_win;
        bus_rdata  = '0;
        if (bus_rd_hit && ofs == OFS_POLL_MASK)
            bus_rdata = latch_q;
    end
endmodule

// File: rtl/irq_latch_bank.sv
// Top level of the interrupt request latch bank: synchronizer, latches and
// software port window. Prioritization is left to the response unit.
module irq_latch_bank
    import irq_latch_pkg::*;
#(
    parameter logic [AW-1:0] BASE_ADDR = 8'hCC
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req_n,
    input  logic [NCH-1:0] auto_clr,
    input  logic [AW-1:0]  bus_addr,
    input  logic           bus_rd,
    input  logic           bus_wr,
    input  logic [NCH-1:0] bus_wdata,
    output logic [NCH-1:0] bus_rdata,
    output logic           bus_rd_hit,
    output logic [NCH-1:0] latch_raw,
    output logic [NCH-1:0] latch_gated,
    output logic [NCH-1:0] ack_n,
    output logic           card_off,
    output logic           chain_block
);
    logic [NCH-1:0]  fall;
    logic [NCH-1:0]  latch_q;
    logic [NCH-1:0]  mask_q;
    logic [NCH-1:0]  hold_q;
    logic [NCTL-1:0] ctrl_q;

    irq_req_sync #(.N(NCH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .req_n (req_n),
        .fall  (fall)
    );

    irq_latch_core #(.N(NCH)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .fall     (fall),
        .hold_n   (hold_q),
        .auto_clr (auto_clr),
        .latch_q  (latch_q)
    );

    irq_port_regs #(.BASE(BASE_ADDR)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .latch_q    (latch_q),
        .bus_rdata  (bus_rdata),
        .bus_rd_hit (bus_rd_hit),
        .mask_q     (mask_q),
        .hold_q     (hold_q),
        .ctrl_q     (ctrl_q)
    );

    assign card_off    = ctrl_q[CTRL_CARD_OFF];
    assign chain_block = ctrl_q[CTRL_CHAIN_BLK];
    assign latch_raw   = latch_q;
    assign latch_gated = card_off ? '0 : (latch_q & mask_q);
    assign ack_n       = ~latch_q;
endmodule

// File: rtl/irq_latch_bank_chk.sv
// Protocol checker for irq_latch_bank, bound to every instance of the top.
module irq_latch_bank_chk #(
    parameter logic [7:0] BASE = 8'hCC
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] bus_addr,
    input logic       bus_rd,
    input logic [7:0] bus_rdata,
    input logic       bus_rd_hit,
    input logic [7:0] auto_clr,
    input logic [7:0] latch_raw,
    input logic [7:0] latch_gated,
    input logic       card_off,
    input logic [7:0] hold_q
);
    logic in_win;
    assign in_win = (bus_addr[7:2] == BASE[7:2]);

    // R4: a gated bit never appears without its raw latch
    a_r4_gated_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_gated & ~latch_raw) == 8'h00);

    // R7: card disable silences the gated outputs
    a_r7_card_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        card_off |-> latch_gated == 8'h00);

    // R6: a held latch is clear after the next edge
    a_r6_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (latch_raw & ~$past(hold_q)) == 8'h00);

    // R8: an auto-clear pulse leaves its latch clear
    a_r8_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_clr != 8'h00) |=> (latch_raw & $past(auto_clr)) == 8'h00);

    // R3: a poll read returns the raw latches
    a_r3_poll_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && in_win && bus_addr[1:0] == 2'd0) |-> (bus_rdata == latch_raw && bus_rd_hit));

    // R10: unused window offsets read zero but still claim the bus
    a_r10_unused_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && in_win && bus_addr[1:0] != 2'd0) |-> (bus_rdata == 8'h00 && bus_rd_hit));

    // R10: addresses outside the window are not claimed
    a_r10_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !in_win |-> (!bus_rd_hit && bus_rdata == 8'h00));
endmodule

bind irq_latch_bank irq_latch_bank_chk #(.BASE(BASE_ADDR)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_rd      (bus_rd),
    .bus_rdata   (bus_rdata),
    .bus_rd_hit  (bus_rd_hit),
    .auto_clr    (auto_clr),
    .latch_raw   (latch_raw),
    .latch_gated (latch_gated),
    .card_off    (card_off),
    .hold_q      (hold_q)
);

// File: tb/irq_latch_bank_test.sv
`timescale 1ns/1ps
module irq_latch_bank_test;
    localparam logic [7:0] BASE = 8'hCC;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_n = 8'hFF;
    logic [7:0] auto_clr = 8'h00;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata, latch_raw, latch_gated, ack_n;
    logic       bus_rd_hit, card_off, chain_block;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    always #2.5 clk = ~clk;

    irq_latch_bank #(.BASE_ADDR(BASE)) uut (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .auto_clr(auto_clr),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rd_hit(bus_rd_hit), .latch_raw(latch_raw),
        .latch_gated(latch_gated), .ack_n(ack_n), .card_off(card_off),
        .chain_block(chain_block)
    );

    // Behavioural reference state
    logic [7:0] m_lat = 0, m_mask = 0, m_hold = 0;
    logic [1:0] m_ctrl = 0;
    logic [7:0] hist[$] = '{8'hFF, 8'hFF, 8'hFF};

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: advance on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_lat = 0; m_mask = 0; m_hold = 0; m_ctrl = 0;
            hist = '{8'hFF, 8'hFF, 8'hFF};
        end else begin
            logic [7:0] edges;
            edges = hist[2] & ~hist[1];
            for (int i = 0; i < 8; i++) begin
                if (!m_hold[i] || auto_clr[i]) m_lat[i] = 1'b0;
                else if (edges[i])             m_lat[i] = 1'b1;
            end
            if (bus_wr && bus_addr[7:2] == BASE[7:2]) begin
                if (bus_addr[1:0] == 2'd0) m_mask = bus_wdata;
                if (bus_addr[1:0] == 2'd1) m_hold = bus_wdata;
                if (bus_addr[1:0] == 2'd2) m_ctrl = bus_wdata[1:0];
            end
            hist.push_front(req_n);
            void'(hist.pop_back());
        end
    end

    // Compare every output against the model between edges
    always @(negedge clk) begin
        if (!done) begin
            logic       hit;
            logic [7:0] exp_rd;
            hit    = bus_rd && bus_addr[7:2] == BASE[7:2];
            exp_rd = (hit && bus_addr[1:0] == 2'd0) ? m_lat : 8'h00;
            chk("R1 latch_raw", latch_raw, m_lat);
            chk("R4 latch_gated", latch_gated, m_ctrl[0] ? 8'h00 : (m_lat & m_mask));
            chk("R9 ack_n", ack_n, ~m_lat);
            chk("R7 ctrl", {6'd0, chain_block, card_off}, {6'd0, m_ctrl});
            chk("R3 rdata", bus_rdata, exp_rd);
            chk("R10 rd_hit", {7'd0, bus_rd_hit}, {7'd0, hit});
        end
    end

    task automatic cyc(input int n = 1);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1; cyc(); bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a);
        bus_addr = a; bus_rd = 1; cyc(); bus_rd = 0;
    endtask

    task automatic pulse(input logic [7:0] lines);
        req_n = req_n & ~lines; cyc(3); req_n = req_n | lines; cyc(3);
    endtask

    initial begin
        cyc(3);
        chk("R11 reset latches", latch_raw, 8'h00);
        chk("R11 reset ctrl", {6'd0, chain_block, card_off}, 8'h00);
        rst_n = 1; cyc();
        // R6: held by reset value, edges ignored
        pulse(8'h01);
        chk("R6 held latch", latch_raw, 8'h00);
        wr(BASE + 1, 8'hFF);
        wr(BASE + 0, 8'h0F);
        // R1: capture delay on channel 6
        req_n[6] = 0; cyc(2);
        chk("R1 not yet set", latch_raw[6] ? 8'h01 : 8'h00, 8'h00);
        cyc(1);
        chk("R1 set after delay", latch_raw[6] ? 8'h01 : 8'h00, 8'h01);
        req_n[6] = 1; cyc(2);
        pulse(8'hBF);
        chk("R1 all set", latch_raw, 8'hFF);
        chk("R5 masked still set", latch_gated, 8'h0F);
        rd(BASE);
        // R5: mask change keeps latches
        wr(BASE + 0, 8'h00);
        chk("R5 mask keeps latch", latch_raw, 8'hFF);
        wr(BASE + 0, 8'hF0);
        // R2 and R8: hold ch3 low, auto-clear, no refire
        req_n[3] = 0; cyc(4);
        auto_clr = 8'h08; cyc(); auto_clr = 8'h00; cyc(5);
        chk("R2 no refire", latch_raw & 8'h08, 8'h00);
        req_n[3] = 1; cyc(3);
        // R8: clear coincides with the set edge on ch5
        auto_clr = 8'h20; cyc(); auto_clr = 8'h00; cyc();
        req_n[5] = 0; cyc(2); auto_clr = 8'h20; cyc(); auto_clr = 8'h00; cyc(2);
        chk("R8 clear wins", latch_raw & 8'h20, 8'h00);
        req_n[5] = 1; cyc(3);
        // R7: control bits, upper bits ignored
        wr(BASE + 2, 8'hFD);
        chk("R7 card off", latch_gated, 8'h00);
        wr(BASE + 2, 8'hFE);
        chk("R7 chain block", {6'd0, chain_block, card_off}, 8'h02);
        wr(BASE + 2, 8'h00);
        // R6: clear through the hold register
        wr(BASE + 1, 8'h7F); cyc();
        chk("R6 hold clears", latch_raw & 8'h80, 8'h00);
        // R10: unused and foreign addresses
        rd(BASE + 1); rd(BASE + 2); rd(BASE + 3); rd(8'h10); rd(BASE + 4);
        wr(BASE + 3, 8'h00); wr(8'h10, 8'h00); wr(BASE - 4, 8'h00);
        chk("R10 writes ignored", latch_gated, latch_raw & 8'hF0);
        // Mixed traffic
        for (int k = 0; k < 3000; k++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r < 4) req_n = req_n ^ 8'($urandom());
            auto_clr = (r == 4) ? 8'(1 << $urandom_range(0, 7)) : 8'h00;
            bus_addr = (r == 9) ? 8'($urandom()) : BASE + 8'($urandom_range(0, 3));
            bus_wdata = 8'($urandom());
            bus_wr = (r == 5) || (r == 9 && bus_addr[0]);
            if (bus_wr && bus_addr == BASE + 1) bus_wdata = bus_wdata | 8'hF0;
            bus_rd = (r >= 6);
            cyc();
            bus_wr = 0; bus_rd = 0; auto_clr = 0;
        end
        // R11: reset in mid-run
        rst_n = 0; cyc(2);
        chk("R11 mid reset", latch_raw, 8'h00);
        rst_n = 1; cyc(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule